// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash and decides when a program or erase that was already launched has finished. After a start pulse it reads the device status word over a simple request/acknowledge bus, keeps the toggle bit from one read and compares it with the next. A toggle bit that holds still means the operation succeeded. A toggle bit that keeps changing while the timeout flag is set leads to one more confirming read pair. If that pair still toggles, the block writes the reset command and reports failure.

The host sees only `busy_o`, `pass_o` and `fail_o`. It may abandon polling at any time with `abort_i`. A later start always opens a fresh read pair and keeps no old toggle sample. A parameterised limit on read pairs forces a fail result, so a device that never settles cannot keep the poller busy forever.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: After reset `busy_o`, `pass_o`, `fail_o` and `mem_req_o` are all low.
- R2: A `start_i` pulse while idle raises `busy_o` on the next cycle. It also launches status reads (`mem_we_o` low) at the `poll_addr_i` value captured at start.
- R3: When the toggle bit (status bit 6) has the same value in both reads of a pair, the block sets `pass_o` after exactly those reads and issues no write.
- R4: When the toggle bit differs within a pair and the timeout flag (status bit 5) of the second read is low, a fresh read pair follows.
- R5: When the toggle bit differs and the timeout flag is high, exactly one confirming pair is read. If its toggle bit is equal, the result is pass with no write.
- R6: When the confirming pair still toggles, the block issues one write of `RST_DATA` to `RST_ADDR`, and `fail_o` rises only after that write is acknowledged.
- R7: When the MAX_PAIRS-th pair toggles with the timeout flag low, the block takes the fail path with the reset write. A MAX_PAIRS of 0 removes the limit.
- R8: `abort_i` returns the block to idle on the next cycle with no result and no write. The next start begins with a new pair and no saved toggle value.
- R9: `pass_o` and `fail_o` are never high together and are low while `busy_o` is high. A result holds until the next start or abort.
- R10: While `mem_req_o` is high and not acknowledged, the request, `mem_we_o` and `mem_addr_o` stay stable, unless an abort occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (ignored while busy) |
| abort_i | input | 1 | Leave polling without a result |
| poll_addr_i | input | AW | Address used for status reads, captured at start |
| busy_o | output | 1 | Polling or reset write in progress |
| pass_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation failed; reset command already written |
| mem_req_o | output | 1 | Bus request, held until acknowledged |
| mem_we_o | output | 1 | 1 = command write, 0 = status read |
| mem_addr_o | output | AW | Bus address |
| mem_wdata_o | output | DW | Write data (reset command) |
| mem_ack_i | input | 1 | Transfer complete; read data valid in this cycle |
| mem_rdata_i | input | DW | Status word |

## Verification
The bench goes after the timeout race. A status word with the timeout flag set must be followed by one confirming pair. A poller that trusted the flag alone would fail an operation that had just finished, and one that ignored it would keep polling. The bench also aborts between the two reads of a pair and then restarts against a steady device. A design that kept the old toggle sample would see a false toggle and take four reads instead of two. It drives a device that never settles, to show the limit ends the loop after exactly the configured number of pairs. It checks that the reset write carries the right address and data and comes before the fail flag.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,   // first read of a poll pair
    ST_RD_B,   // second read, compare
    ST_CHK_A,  // first read of confirm pair after timeout flag
    ST_CHK_B,
    ST_RST     // reset command write
  } poll_st_e;
endpackage

// File: rtl/tgl_poll_cmp.sv
module tgl_poll_cmp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic save_i,
  input  logic tgl_bit_i,
  input  logic tmo_bit_i,
  output logic toggled_o,
  output logic timeout_o
);
  logic ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= 1'b0;
    else if (clr_i)  ref_q <= 1'b0;
    else if (save_i) ref_q <= tgl_bit_i;
  end

  assign toggled_o = tgl_bit_i ^ ref_q;
  assign timeout_o = tmo_bit_i;
endmodule

// File: rtl/tgl_poll_cnt.sv
module tgl_poll_cnt #(
  parameter int unsigned MAX_PAIRS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_lim_o
);
  generate
    if (MAX_PAIRS == 0) begin : g_unlimited
      assign at_lim_o = 1'b0;
    end else begin : g_limited
      localparam int unsigned CW = (MAX_PAIRS < 2) ? 1 : $clog2(MAX_PAIRS);
      localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     cnt_q <= '0;
        else if (clr_i)                  cnt_q <= '0;
        else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end

      assign at_lim_o = (cnt_q == LAST);

      // R7
      cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
  import tgl_poll_pkg::*;
#(
  parameter int unsigned AW        = 24,
  parameter int unsigned DW        = 16,
  parameter int unsigned TGL_BIT   = 6,
  parameter int unsigned TMO_BIT   = 5,
  parameter logic [AW-1:0] RST_ADDR = AW'('h555),
  parameter logic [DW-1:0] RST_DATA = DW'('h00F0),
  parameter int unsigned MAX_PAIRS = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] poll_addr_i,
  output logic          busy_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  poll_st_e      st_q;
  logic [AW-1:0] addr_q;
  logic          pass_q, fail_q;
  logic          toggled, timeout, at_lim;
  logic          rd_ack, save, clr, inc;
  logic          unused_rdata;

  assign unused_rdata = ^mem_rdata_i;

  assign rd_ack = mem_ack_i && (st_q inside {ST_RD_A, ST_RD_B, ST_CHK_A, ST_CHK_B});
  assign save   = rd_ack && (st_q inside {ST_RD_A, ST_CHK_A});
  assign clr    = abort_i || (st_q == ST_IDLE);
  assign inc    = mem_ack_i && (st_q == ST_RD_B) && toggled && !timeout;

  tgl_poll_cmp i_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .save_i    (save),
    .tgl_bit_i (mem_rdata_i[TGL_BIT]),
    .tmo_bit_i (mem_rdata_i[TMO_BIT]),
    .toggled_o (toggled),
    .timeout_o (timeout)
  );

  tgl_poll_cnt #(.MAX_PAIRS(MAX_PAIRS)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .inc_i    (inc),
    .at_lim_o (at_lim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (abort_i) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RD_A;
          addr_q <= poll_addr_i;
          pass_q <= 1'b0;
          fail_q <= 1'b0;
        end
        ST_RD_A:  if (mem_ack_i) st_q <= ST_RD_B;
        ST_CHK_A: if (mem_ack_i) st_q <= ST_CHK_B;
        ST_RD_B: if (mem_ack_i) begin
          if (!toggled) begin
            st_q   <= ST_IDLE;
            pass_q <= 1'b1;
          end else if (timeout) st_q <= ST_CHK_A;  // toggle may stop as flag rises
          else if (at_lim)      st_q <= ST_RST;
          else                  st_q <= ST_RD_A;
        end
        ST_CHK_B: if (mem_ack_i) begin
          if (!toggled) begin
            st_q   <= ST_IDLE;
            pass_q <= 1'b1;
          end else st_q <= ST_RST;
        end
        ST_RST: if (mem_ack_i) begin
          st_q   <= ST_IDLE;
          fail_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (st_q == ST_RST);
  assign mem_addr_o  = mem_we_o ? RST_ADDR : addr_q;
  assign mem_wdata_o = RST_DATA;

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !abort_i |=> busy_o && !mem_we_o);
  // R6
  fail_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));
  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !pass_o && !fail_o);
  // R9
  result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o) && !(busy_o && (pass_o || fail_o)));
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !abort_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));
endmodule

// File: tb/test_tgl_poll_ctrl.sv
module test_tgl_poll_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam logic [AW-1:0] RA = 24'h000AAA;
  localparam logic [DW-1:0] RD = 16'h00F0;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic busy, pass, fail, req, we, ack;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  logic [DW-1:0] resp [16];
  logic [3:0]    ridx;
  int            rd_cnt, wr_cnt;
  logic [AW-1:0] wr_addr, last_raddr;
  logic [DW-1:0] wr_data;
  logic          clr = 1'b0;
  int            n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tgl_poll_ctrl #(.AW(AW), .DW(DW), .TGL_BIT(6), .TMO_BIT(5),
                  .RST_ADDR(RA), .RST_DATA(RD), .MAX_PAIRS(MAXP)) i_tgl_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .poll_addr_i(paddr), .busy_o(busy), .pass_o(pass), .fail_o(fail),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata));

  // one-wait-state device model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      ack <= 1'b0; ridx <= '0; rd_cnt <= 0; wr_cnt <= 0;
      rdata <= '0; wr_addr <= '0; wr_data <= '0; last_raddr <= '0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        wr_cnt <= wr_cnt + 1; wr_addr <= addr; wr_data <= wdata;
      end else begin
        rdata <= resp[ridx]; ridx <= ridx + 1'b1;
        rd_cnt <= rd_cnt + 1; last_raddr <= addr;
      end
    end else ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [DW-1:0] a, input logic [DW-1:0] b);
    for (int i = 0; i < 16; i++) resp[i] = (i % 2 == 0) ? a : b;
  endtask

  task automatic clear_dev();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] a);
    paddr = a;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !pass && !fail, "R2 busy after start", busy, 1);
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    chk(!busy, "R2 completes", busy, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !pass && !fail && !req, "R1 reset outputs", {busy, pass, fail, req}, 0);
  endtask

  task automatic t_steady();
    clear_dev(); fill(16'h0040, 16'h0040);
    run(24'h012345);
    chk(pass && !fail, "R3 pass", pass, 1);
    chk(rd_cnt == 2, "R3 read count", rd_cnt, 2);
    chk(wr_cnt == 0, "R3 no write", wr_cnt, 0);
    chk(last_raddr == 24'h012345, "R2 poll address", last_raddr, 24'h012345);
    repeat (5) @(negedge clk);
    chk(pass && !fail, "R9 result held", pass, 1);
  endtask

  task automatic t_toggle_then_steady();
    clear_dev(); fill(16'h0040, 16'h0040); resp[0] = 16'h0000;
    run(24'h000100);
    chk(pass && !fail, "R4 pass after second pair", pass, 1);
    chk(rd_cnt == 4, "R4 read count", rd_cnt, 4);
  endtask

  task automatic t_tmo_recheck_ok();
    clear_dev(); fill(16'h0040, 16'h0040); resp[0] = 16'h0000; resp[1] = 16'h0060;
    run(24'h000200);
    chk(pass && !fail, "R5 recheck pass", {pass, fail}, 2);
    chk(rd_cnt == 4, "R5 read count", rd_cnt, 4);
    chk(wr_cnt == 0, "R5 no write", wr_cnt, 0);
  endtask

  task automatic t_tmo_recheck_fail();
    clear_dev(); fill(16'h0020, 16'h0060); resp[0] = 16'h0000;
    run(24'h000300);
    chk(fail && !pass, "R6 fail", {pass, fail}, 1);
    chk(rd_cnt == 4, "R6 read count", rd_cnt, 4);
    chk(wr_cnt == 1, "R6 one write", wr_cnt, 1);
    chk(wr_addr == RA, "R6 write address", wr_addr, RA);
    chk(wr_data == RD, "R6 write data", wr_data, RD);
  endtask

  task automatic t_limit();
    clear_dev(); fill(16'h0000, 16'h0040);
    run(24'h000400);
    chk(fail && !pass, "R7 limit fail", {pass, fail}, 1);
    chk(rd_cnt == 2 * MAXP, "R7 read count", rd_cnt, 2 * MAXP);
    chk(wr_cnt == 1, "R7 reset write", wr_cnt, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!fail && !pass, "R9 cleared by start", fail, 0);
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic t_abort();
    clear_dev(); fill(16'h0000, 16'h0040);
    paddr = 24'h000500;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 50 && rd_cnt < 1; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(!busy && !pass && !fail, "R8 abort idle", {busy, pass, fail}, 0);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 0, "R8 no write", wr_cnt, 0);
    chk(!req, "R8 bus quiet", req, 0);
    clear_dev(); fill(16'h0040, 16'h0040);
    run(24'h000500);
    chk(pass && rd_cnt == 2, "R8 fresh pair on restart", rd_cnt, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_steady();
    t_toggle_then_steady();
    t_tmo_recheck_ok();
    t_tmo_recheck_fail();
    t_limit();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule